// File: doc/BRIEF.md
# Indexed Address and Branch Sequencer

This block steps through the bus cycles of two instruction classes of an 8-bit processor with a 16-bit address space. The first class is effective-address formation for absolute addressing plus an index register. The second class is relative conditional branches. The block owns the read side of one memory bus. It is given the program counter, both index values and the already-evaluated branch condition, and it issues one read per clock until the sequence ends. This includes the wasted "dummy" reads that the hardware performs when an address carry has to ripple into the upper byte.

A one-bit parameter selects between two generations of the processor. The two generations disagree on which address the page-crossing penalty cycle reads. The older one reads the half-corrected address: the old upper byte joined with the new lower byte. The newer one re-reads a program-counter value instead. Everything else is common to both. Bus-cycle counts given here exclude the opcode fetch, which happens before the block is started. A branch therefore takes 1, 2 or 3 bus cycles here, which is 2, 3 or 4 cycles for the whole instruction.

The block is started with a one-clock `start` while idle. The final effective address and the updated program counter appear on `ea` and `pc_out` at the clock edge that ends the cycle carrying `done`. They are held there until the next start.

Top module: `idx_branch_seq`

## Requirements
- R1: While reset is applied and after it is released, the block is idle: `bus_rd` and `done` are low.
- R2: A start with `mode` 2'b00 (index X) or 2'b01 (index Y) reads the base low byte at the latched PC, then the high byte at PC+1. After these two reads, `pc_out` equals the starting PC plus 2, modulo 2^16.
- R3: The indexed effective address on `ea` is the 16-bit base plus the zero-extended 8-bit index, wrapping modulo 2^16. `mode` bit 0 picks the index: 0 selects `x_in`, 1 selects `y_in`.
- R4: When adding the index carries into the upper byte, a third read follows. The older variant (`NEWER`=0) reads {base high byte, effective-address low byte}. The newer variant reads the PC after both operand bytes, which is the start PC plus 2.
- R5: When no carry occurs but `force_extra` was high at start, a third read of the final effective address follows.
- R6: With no carry and `force_extra` low, the indexed sequence is exactly two reads.
- R7: A start with `mode` 2'b10 reads the signed offset at PC. If `take` was low at start, the sequence ends after that single read, with `pc_out` and `ea` both equal to PC+1.
- R8: For a taken branch, a second read at PC+1 follows. `pc_out` and `ea` then equal PC+1 plus the sign-extended offset.
- R9: If the taken target's upper byte differs from that of PC+1, a third read follows. The older variant reads {upper byte of PC+1, target low byte}. The newer variant reads PC+1 again.
- R10: `bus_rd` is high on every clock of a sequence and on no other. `done` is high for exactly one clock, the last read of the sequence. `pc_out` does not change while idle without a start.
- R11: `start` is ignored while a sequence runs, as are changes to `mode`, `pc_in` and the index inputs during that time. A start with `mode` 2'b11 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (sampled only while idle) |
| mode | input | 2 | 00 index X, 01 index Y, 10 branch, 11 reserved |
| force_extra | input | 1 | Indexed: always spend the third cycle |
| take | input | 1 | Branch condition result |
| pc_in | input | 16 | PC pointing at the first operand byte |
| x_in | input | 8 | X index value |
| y_in | input | 8 | Y index value |
| rd_data | input | 8 | Read data for the current bus address |
| bus_addr | output | 16 | Bus read address |
| bus_rd | output | 1 | Read strobe, high on every busy clock |
| done | output | 1 | High in the last bus cycle |
| ea | output | 16 | Effective address or branch target |
| pc_out | output | 16 | Updated program counter |

## Verification
Any corrupted state in this block shows on the bus address within the same or the following clock. A wrong carry or page-cross decision adds or drops a read, so `done` lands one cycle off and the read count differs. A wrong variant choice shows only in the third read's address. For that reason, both variants run side by side on identical stimulus, and every bus cycle is compared against an independently computed address list. Wrapping at the top of the address space and branches in both directions across page edges are covered.

// File: rtl/idx_branch_seq.sv
module idx_branch_seq #(
  parameter bit NEWER = 1'b0,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          mode,
  input  logic                force_extra,
  input  logic                take,
  input  logic [2*DW-1:0]     pc_in,
  input  logic [DW-1:0]       x_in,
  input  logic [DW-1:0]       y_in,
  input  logic [DW-1:0]       rd_data,
  output logic [2*DW-1:0]     bus_addr,
  output logic                bus_rd,
  output logic                done,
  output logic [2*DW-1:0]     ea,
  output logic [2*DW-1:0]     pc_out
);
  localparam int AW = 2 * DW;

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_FIX, S_OFF, S_TAKE, S_BFIX} st_t;
  st_t st;

  logic [AW-1:0] pc_r, base_r, guess_r, ea_r;
  logic [DW-1:0] lo_r, idx_r, off_r;
  logic          extra_r, take_r, cross_r;

  wire [DW:0]    lo_sum   = {1'b0, lo_r} + {1'b0, idx_r};
  wire           ix_cross = lo_sum[DW];
  wire [AW-1:0]  idx_ea   = {rd_data, lo_r} + {{DW{1'b0}}, idx_r};
  wire [AW-1:0]  pc_inc   = pc_r + {{(AW-1){1'b0}}, 1'b1};
  wire [AW-1:0]  br_tgt   = pc_r + {{DW{off_r[DW-1]}}, off_r};
  wire           br_cross = br_tgt[AW-1:DW] != pc_r[AW-1:DW];

  always_comb begin
    case (st)
      S_FIX:   bus_addr = cross_r ? (NEWER ? pc_r : guess_r) : ea_r;
      S_BFIX:  bus_addr = NEWER ? base_r : {base_r[AW-1:DW], pc_r[DW-1:0]};
      default: bus_addr = pc_r;
    endcase
  end

  assign bus_rd = (st != S_IDLE);
  assign done   = (st == S_HI   && !ix_cross && !extra_r) ||
                  (st == S_OFF  && !take_r) ||
                  (st == S_TAKE && !br_cross) ||
                  (st == S_FIX) || (st == S_BFIX);
  assign ea     = ea_r;
  assign pc_out = pc_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pc_r    <= '0;
      base_r  <= '0;
      guess_r <= '0;
      ea_r    <= '0;
      lo_r    <= '0;
      idx_r   <= '0;
      off_r   <= '0;
      extra_r <= 1'b0;
      take_r  <= 1'b0;
      cross_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start && mode != 2'b11) begin
          pc_r    <= pc_in;
          idx_r   <= mode[0] ? y_in : x_in;
          extra_r <= force_extra;
          take_r  <= take;
          st      <= mode[1] ? S_OFF : S_LO;
        end
        S_LO: begin
          lo_r <= rd_data;
          pc_r <= pc_inc;
          st   <= S_HI;
        end
        S_HI: begin
          pc_r    <= pc_inc;
          ea_r    <= idx_ea;
          guess_r <= {rd_data, lo_sum[DW-1:0]};
          cross_r <= ix_cross;
          st      <= (ix_cross || extra_r) ? S_FIX : S_IDLE;
        end
        S_OFF: begin
          off_r <= rd_data;
          pc_r  <= pc_inc;
          ea_r  <= pc_inc;
          st    <= take_r ? S_TAKE : S_IDLE;
        end
        S_TAKE: begin
          base_r <= pc_r;
          pc_r   <= br_tgt;
          ea_r   <= br_tgt;
          st     <= br_cross ? S_BFIX : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_branch_seq_chk.sv
module idx_branch_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    mode,
  input logic          take,
  input logic [AW-1:0] pc_in,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          done,
  input logic [AW-1:0] pc_out
);
  a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bus_rd);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !bus_rd));

  a_r10_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !start) |=> $stable(pc_out));

  a_r11_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && start && mode == 2'b11) |=> !bus_rd);

  a_r2_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && start && !mode[1]) |=> (bus_rd && !done && bus_addr == $past(pc_in)));

  a_r7_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && start && mode == 2'b10 && !take) |=> (done && bus_addr == $past(pc_in)));
endmodule

bind idx_branch_seq idx_branch_seq_chk #(.AW(2*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .take(take),
  .pc_in(pc_in), .bus_addr(bus_addr), .bus_rd(bus_rd), .done(done), .pc_out(pc_out)
);

// File: tb/sim_idx_branch_seq.sv
module sim_idx_branch_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic fx = 1'b0, take = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0] x_in = '0, y_in = '0;
  logic [15:0] m_p = '0;
  logic [7:0] m_b0 = '0, m_b1 = '0;

  logic [15:0] a0, a1, ea0, ea1, pc0, pc1;
  logic rd0, rd1, dn0, dn1;
  logic [7:0] d0, d1;
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem(input logic [15:0] a);
    logic [15:0] q;
    q = m_p + 16'd1;
    if (a == m_p) return m_b0;
    if (a == q) return m_b1;
    return 8'hEE;
  endfunction

  assign d0 = mem(a0);
  assign d1 = mem(a1);

  idx_branch_seq #(.NEWER(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .force_extra(fx), .take(take),
    .pc_in(pc_in), .x_in(x_in), .y_in(y_in), .rd_data(d0),
    .bus_addr(a0), .bus_rd(rd0), .done(dn0), .ea(ea0), .pc_out(pc0));

  idx_branch_seq #(.NEWER(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .force_extra(fx), .take(take),
    .pc_in(pc_in), .x_in(x_in), .y_in(y_in), .rd_data(d1),
    .bus_addr(a1), .bus_rd(rd1), .done(dn1), .ea(ea1), .pc_out(pc1));

  task automatic eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] md, input logic f, input logic t,
                     input logic [15:0] pc, input logic [7:0] xv, input logic [7:0] yv,
                     input logic [7:0] b0, input logic [7:0] b1, input bit hold,
                     input string req);
    logic [15:0] e0[4], e1[4];
    logic [15:0] base, sum, nxt, tgt, eea, epc;
    logic [7:0] iv;
    int n;
    if (!md[1]) begin
      iv   = md[0] ? yv : xv;
      base = {b1, b0};
      sum  = base + {8'h00, iv};
      nxt  = pc + 16'd2;
      e0[0] = pc; e1[0] = pc;
      e0[1] = pc + 16'd1; e1[1] = pc + 16'd1;
      n = 2;
      if ({1'b0, b0} + {1'b0, iv} > 9'd255) begin
        e0[2] = {b1, sum[7:0]}; e1[2] = nxt; n = 3;
      end else if (f) begin
        e0[2] = sum; e1[2] = sum; n = 3;
      end
      eea = sum; epc = nxt;
    end else begin
      nxt = pc + 16'd1;
      e0[0] = pc; e1[0] = pc;
      n = 1; eea = nxt; epc = nxt;
      if (t) begin
        tgt = nxt + {{8{b0[7]}}, b0};
        e0[1] = nxt; e1[1] = nxt; n = 2;
        if (tgt[15:8] != nxt[15:8]) begin
          e0[2] = {nxt[15:8], tgt[7:0]}; e1[2] = nxt; n = 3;
        end
        eea = tgt; epc = tgt;
      end
    end
    m_p = pc; m_b0 = b0; m_b1 = b1;
    mode = md; fx = f; take = t; pc_in = pc; x_in = xv; y_in = yv;
    start = 1'b1;
    @(negedge clk);
    if (!hold) start = 1'b0;
    else begin
      mode = ~md; pc_in = ~pc; x_in = ~xv; y_in = ~yv; take = ~t; fx = ~f;
    end
    for (int i = 0; i < n; i++) begin
      eq({req, " R10 rd old"}, {15'd0, rd0}, 16'd1);
      eq({req, " R10 rd new"}, {15'd0, rd1}, 16'd1);
      eq({req, " addr old"}, a0, e0[i]);
      eq({req, " addr new"}, a1, e1[i]);
      eq({req, " R10 done old"}, {15'd0, dn0}, {15'd0, (i == n-1)});
      eq({req, " R10 done new"}, {15'd0, dn1}, {15'd0, (i == n-1)});
      @(negedge clk);
    end
    start = 1'b0;
    eq({req, " R10 idle old"}, {15'd0, rd0}, 16'd0);
    eq({req, " R10 idle new"}, {15'd0, rd1}, 16'd0);
    eq({req, " ea old"}, ea0, eea);
    eq({req, " ea new"}, ea1, eea);
    eq({req, " pc old"}, pc0, epc);
    eq({req, " pc new"}, pc1, epc);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    eq("R1 rd in reset", {15'd0, rd0 | rd1}, 16'd0);
    eq("R1 done in reset", {15'd0, dn0 | dn1}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    eq("R1 rd after reset", {15'd0, rd0 | rd1}, 16'd0);
    eq("R1 done after reset", {15'd0, dn0 | dn1}, 16'd0);

    // R2 R3 R6: X, no carry, two reads
    run(2'b00, 1'b0, 1'b0, 16'h1234, 8'h05, 8'h77, 8'h10, 8'h20, 1'b0, "R2 R3 R6");
    // R4 R3: Y, carry into page
    run(2'b01, 1'b0, 1'b0, 16'h1234, 8'h01, 8'h20, 8'hF0, 8'h20, 1'b0, "R4 R3 Y");
    // R5: forced third cycle reads ea
    run(2'b00, 1'b1, 1'b0, 16'h0800, 8'h03, 8'h00, 8'h40, 8'h55, 1'b0, "R5");
    // R3 R4: wrap at top of address space, PC wraps too
    run(2'b00, 1'b0, 1'b0, 16'hFFFF, 8'h20, 8'h00, 8'hF0, 8'hFF, 1'b0, "R3 R4 wrap");
    // R7: branch not taken
    run(2'b10, 1'b0, 1'b0, 16'h3000, 8'h00, 8'h00, 8'h10, 8'h00, 1'b0, "R7");
    // R8: taken forward, same page
    run(2'b10, 1'b0, 1'b1, 16'h3000, 8'h00, 8'h00, 8'h10, 8'h00, 1'b0, "R8");
    // R9: taken backward across page
    run(2'b10, 1'b0, 1'b1, 16'h3005, 8'h00, 8'h00, 8'h80, 8'h00, 1'b0, "R9 back");
    // R9: taken forward across page
    run(2'b10, 1'b0, 1'b1, 16'h30F0, 8'h00, 8'h00, 8'h7F, 8'h00, 1'b0, "R9 fwd");
    // R11: inputs changed and start held while busy
    run(2'b10, 1'b0, 1'b1, 16'h4080, 8'h00, 8'h00, 8'hF0, 8'h00, 1'b1, "R11 R8 hold");
    run(2'b01, 1'b0, 1'b0, 16'h5000, 8'h00, 8'hC0, 8'h80, 8'h12, 1'b1, "R11 R4 hold");

    // R11: reserved mode starts nothing; R10: pc_out held
    mode = 2'b11; pc_in = 16'hABCD; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    eq("R11 reserved rd", {15'd0, rd0 | rd1}, 16'd0);
    @(negedge clk);
    eq("R11 reserved rd later", {15'd0, rd0 | rd1}, 16'd0);
    eq("R10 R11 pc held old", pc0, 16'h5002);
    eq("R10 R11 pc held new", pc1, 16'h5002);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule